// File: doc/BRIEF.md
# Geometric Sampling Miss-Curve Monitor

This block watches a stream of last-level-cache line addresses and gathers the data from which software builds a miss curve. The curve covers both very small and very large cache allocations. It keeps a small set-associative shadow tag array. Each set is held in recency order, so way 0 holds the most recently used address. Each deeper way admits addresses at a lower rate than the way before it. Because of this, a shallow way stands for a thin slice of modelled capacity and a deep way stands for a wide one. A few dozen ways can therefore span from a fraction of a bank up to the whole cache.

Two hashes are taken from every address. The first picks the set. The second is compared against a per-way threshold register, and an address may live in way w only while its hash is below that way's threshold. A hit at way w increments hit counter w. Every sampled access also increments a total counter. From these counts software derives the hits and misses for any allocation size. The thresholds reset to a geometric series, and software can reprogram them. A clear pulse zeroes the counters but keeps the shadow tags warm.

Accesses enter through a valid/ready handshake. The lookup and its update take two cycles, so the block accepts at most one access every other cycle.

Top module: `geo_miss_monitor`

## Requirements
- R1: After reset, acc_ready is 1, every counter reads 0 and no address hits on its first access.
- R2: An access is taken on a rising edge where acc_valid and acc_ready are both 1. acc_ready is 0 during the following cycle. Counters are unchanged during that cycle and show the access's effect after the next rising edge. After that edge acc_ready returns to 1.
- R3: The set index is addr[SB-1:0] XOR addr[2*SB-1:SB], with SB = log2(SETS). The sample hash is addr[AW-1:AW-HW] XOR addr[HW-1:0]. An access is sampled when its hash is below threshold 0. A miss that is not sampled changes neither tags nor counters.
- R4: A hit at way w increments hit counter w and the total counter by one. The hit entry moves to way 0. Entries at ways 0..w-1 move down one way. Entries at ways above w stay where they are.
- R5: A sampled miss increments only the total counter. The address is inserted at way 0, every entry moves down one way, and the entry at the last way is lost.
- R6: An entry moving into way w is dropped unless its sample hash is below threshold w.
- R7: At reset, threshold w is 2^HW >> (w / HALF_EVERY), using integer division. A write with thr_we set stores thr_val into threshold thr_sel. The new value applies to accesses taken after that edge.
- R8: Every counter is CW bits wide and stays at 2^CW-1 instead of wrapping.
- R9: A clr pulse zeroes all counters and keeps the tags. If an update falls on the same edge, the clear wins.
- R10: rd_data shows hit counter rd_sel when rd_sel < WAYS, the total counter when rd_sel = WAYS, and 0 for any larger rd_sel.
- R11: An access affects only the tags of its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access address is offered |
| acc_ready | output | 1 | The block can take an access |
| acc_addr | input | AW | Line address of the access |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | log2(WAYS) | Way whose threshold is written |
| thr_val | input | HW+1 | New threshold value |
| clr | input | 1 | Zero all counters |
| rd_sel | input | log2(WAYS+1) | Counter selected for readout |
| rd_data | output | CW | Selected counter value |

## Verification
An access taken at edge N is still invisible in the counters just after N. Its effect shows just after edge N+1, and acc_ready is low only between those two edges. The bench therefore reads the counters once in the busy cycle, expecting the old values, and once after the second edge, expecting the new values. Every read happens at the falling edge. Threshold writes and clear pulses take effect at the edge that samples them, so each is driven at a falling edge and checked one edge later. Expected counts come from a bench-side model of the recency and threshold rules. The model is compared across all readout selectors after every access of a long sweep.

// File: rtl/geo_miss_monitor.sv
module geo_miss_monitor #(
  parameter int SETS       = 16,
  parameter int WAYS       = 64,
  parameter int AW         = 32,
  parameter int HW         = 16,
  parameter int CW         = 32,
  parameter int HALF_EVERY = 7,
  localparam int SB = $clog2(SETS),
  localparam int WB = $clog2(WAYS),
  localparam int RB = $clog2(WAYS + 1),
  localparam int TW = HW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic          thr_we,
  input  logic [WB-1:0] thr_sel,
  input  logic [TW-1:0] thr_val,
  input  logic          clr,
  input  logic [RB-1:0] rd_sel,
  output logic [CW-1:0] rd_data
);

  function automatic logic [SB-1:0] set_of(input logic [AW-1:0] a);
    return a[SB-1:0] ^ a[2*SB-1:SB];
  endfunction

  function automatic logic [HW-1:0] samp_of(input logic [AW-1:0] a);
    return a[AW-1:AW-HW] ^ a[HW-1:0];
  endfunction

  function automatic logic [TW-1:0] thr_default(input int w);
    logic [TW-1:0] top;
    top = TW'(1) << HW;
    return top >> (w / HALF_EVERY);
  endfunction

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == {CW{1'b1}}) ? v : v + 1'b1;
  endfunction

  logic [AW-1:0]   tag_q [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];
  logic [TW-1:0]   thr_q [WAYS];
  logic [CW-1:0]   hit_q [WAYS];
  logic [CW-1:0]   tot_q;
  logic            busy_q;
  logic [AW-1:0]   a_q;

  logic [SB-1:0]   set_s;
  logic [HW-1:0]   samp_s;
  logic [WAYS-1:0] match;
  logic            hit, sampled, upd;
  logic [WB-1:0]   hw_idx;
  logic [AW-1:0]   nt [WAYS];
  logic [WAYS-1:0] nv;

  assign acc_ready = !busy_q;
  assign set_s     = set_of(a_q);
  assign samp_s    = samp_of(a_q);
  assign hit       = |match;
  assign sampled   = samp_s < thr_q[0];
  assign upd       = busy_q && (hit || sampled);

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (busy_q) busy_q <= 1'b0;
    else if (acc_valid) busy_q <= 1'b1;
  end

  always_ff @(posedge clk)
    if (acc_valid && acc_ready) a_q <= acc_addr;

  always_comb begin
    hw_idx = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = vld_q[set_s][w] && (tag_q[set_s][w] == a_q);
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hw_idx = WB'(w);
  end

  always_comb begin
    nt[0] = a_q;
    nv[0] = 1'b1;
    for (int w = 1; w < WAYS; w++) begin
      if (!hit || WB'(w) <= hw_idx) begin
        nt[w] = tag_q[set_s][w-1];
        nv[w] = vld_q[set_s][w-1] && (samp_of(tag_q[set_s][w-1]) < thr_q[w]);
      end else begin
        nt[w] = tag_q[set_s][w];
        nv[w] = vld_q[set_s][w];
      end
    end
  end

  always_ff @(posedge clk)
    if (upd)
      for (int w = 0; w < WAYS; w++) tag_q[set_s][w] <= nt[w];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (upd) begin
      vld_q[set_s] <= nv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) thr_q[w] <= thr_default(w);
    end else if (thr_we) begin
      thr_q[thr_sel] <= thr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int w = 0; w < WAYS; w++) hit_q[w] <= '0;
      tot_q <= '0;
    end else if (busy_q && hit) begin
      hit_q[hw_idx] <= sat_inc(hit_q[hw_idx]);
      tot_q         <= sat_inc(tot_q);
    end else if (busy_q && sampled) begin
      tot_q <= sat_inc(tot_q);
    end
  end

  assign rd_data = (rd_sel < RB'(WAYS)) ? hit_q[rd_sel[WB-1:0]] :
                   (rd_sel == RB'(WAYS)) ? tot_q : '0;

  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> !acc_ready);

  p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |=> acc_ready);

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot0(match));

  p_tot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (tot_q == $past(tot_q) || tot_q == $past(tot_q) + 1'b1));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_q == {CW{1'b1}} && !clr) |=> tot_q == {CW{1'b1}});

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tot_q == '0);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !clr) |=> $stable(tot_q));

endmodule

// File: tb/geo_miss_monitor_tb.sv
module geo_miss_monitor_tb_top;
  localparam int SETS = 2, WAYS = 4, AW = 8, HW = 4, CW = 4, HALF = 1;
  localparam int MAXC = 15;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, thr_we = 0, clr = 0;
  logic acc_ready;
  logic [7:0] acc_addr = 0;
  logic [1:0] thr_sel = 0;
  logic [4:0] thr_val = 0;
  logic [2:0] rd_sel = 0;
  logic [3:0] rd_data;

  int tests = 0, fails = 0;
  logic [7:0] mt [SETS][WAYS];
  bit mv [SETS][WAYS];
  int mc [WAYS];
  int mtot;
  int mthr [WAYS];

  always #5 clk = ~clk;

  geo_miss_monitor #(.SETS(SETS), .WAYS(WAYS), .AW(AW), .HW(HW), .CW(CW),
    .HALF_EVERY(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .thr_we(thr_we), .thr_sel(thr_sel), .thr_val(thr_val),
    .clr(clr), .rd_sel(rd_sel), .rd_data(rd_data));

  function automatic int mset(input logic [7:0] a);
    return int'(a[0] ^ a[1]);
  endfunction
  function automatic int msamp(input logic [7:0] a);
    return int'(a[7:4] ^ a[3:0]);
  endfunction
  function automatic int inc(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int sel, output int v);
    rd_sel = 3'(sel);
    #1 v = int'(rd_data);
  endtask

  task automatic compare_all(input string req);
    int v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      chk(req, v, i < WAYS ? mc[i] : (i == WAYS ? mtot : 0));
    end
  endtask

  task automatic model_access(input logic [7:0] a);
    int s, hw;
    s = mset(a);
    hw = -1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mv[s][w] && mt[s][w] == a) hw = w;
    if (hw >= 0) begin
      mc[hw] = inc(mc[hw]);
      mtot = inc(mtot);
    end else if (msamp(a) < mthr[0]) begin
      mtot = inc(mtot);
      hw = WAYS - 1;
    end else return;
    for (int w = hw; w >= 1; w--) begin
      mt[s][w] = mt[s][w-1];
      mv[s][w] = mv[s][w-1] && (msamp(mt[s][w-1]) < mthr[w]);
    end
    mt[s][0] = a;
    mv[s][0] = 1;
  endtask

  task automatic access(input logic [7:0] a, input bit clr_mid);
    int v;
    @(negedge clk);
    chk("R2 ready before", int'(acc_ready), 1);
    acc_valid = 1;
    acc_addr = a;
    @(negedge clk);
    acc_valid = 0;
    chk("R2 ready low in busy cycle", int'(acc_ready), 0);
    rd(WAYS, v);
    chk("R2 total not yet updated", v, mtot);
    if (clr_mid) clr = 1;
    @(negedge clk);
    clr = 0;
    model_access(a);
    if (clr_mid) begin
      for (int w = 0; w < WAYS; w++) mc[w] = 0;
      mtot = 0;
    end
    chk("R2 ready back", int'(acc_ready), 1);
  endtask

  task automatic set_thr(input int sel, input int val);
    @(negedge clk);
    thr_we = 1;
    thr_sel = 2'(sel);
    thr_val = 5'(val);
    @(negedge clk);
    thr_we = 0;
    mthr[sel] = val;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    for (int w = 0; w < WAYS; w++) mc[w] = 0;
    mtot = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    for (int w = 0; w < WAYS; w++) begin mc[w] = 0; mthr[w] = 16 >> (w / HALF); end
    mtot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(acc_ready), 1);
    compare_all("R1 counters after reset");

    access(8'h03, 0);
    rd(0, v); chk("R1 first access is no hit", v, 0);
    rd(WAYS, v); chk("R5 total after sampled miss", v, 1);
    access(8'h00, 0);
    access(8'h03, 0);
    rd(1, v); chk("R4 hit counted at way 1", v, 1);
    compare_all("R4 after hit");
    access(8'hA0, 0);
    access(8'h00, 0);
    access(8'hA0, 0);
    rd(1, v); chk("R6 dropped entry gives no hit", v, 1);
    compare_all("R6 threshold drop");

    access(8'h01, 0);
    for (int i = 0; i < 5; i++) access(8'(8'h10 * i), 0);
    access(8'h01, 0);
    rd(0, v); chk("R11 other set untouched", v, 1);
    compare_all("R11 sets independent");
    access(8'h00, 0);
    access(8'h10, 0);
    access(8'h20, 0);
    access(8'h00, 0);
    compare_all("R5 shift and R4 order");

    pulse_clr();
    compare_all("R9 clear zeroes counters");
    access(8'h00, 0);
    rd(0, v); chk("R9 tags kept after clear", v, 1);
    access(8'h20, 1);
    compare_all("R9 clear wins over update");

    set_thr(0, 8);
    access(8'hF0, 0);
    access(8'hF0, 0);
    compare_all("R3 unsampled miss ignored");
    rd(WAYS, v); chk("R3 total unchanged by unsampled", v, mtot);
    set_thr(2, 16);
    access(8'h50, 0);
    access(8'h30, 0);
    access(8'h60, 0);
    compare_all("R7 programmed threshold");

    for (int i = 0; i < 20; i++) access(8'h00, 0);
    rd(0, v); chk("R8 hit counter saturates", v, MAXC);
    rd(WAYS, v); chk("R8 total saturates", v, MAXC);
    compare_all("R8 saturation");

    for (int i = 5; i < 8; i++) begin
      rd(i, v); chk("R10 out of range select reads 0", v, 0);
    end

    set_thr(0, 16);
    set_thr(1, 12);
    set_thr(2, 8);
    set_thr(3, 4);
    for (int pass = 0; pass < 2; pass++) begin
      pulse_clr();
      for (int k = 0; k < 300; k++) begin
        access(8'(((k * 13) % 23) * (pass + 7) + pass), 0);
        compare_all("R4 R5 R6 sweep");
      end
      set_thr(1, 10);
      set_thr(3, 6);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule